// File: doc/BRIEF.md
# Keyboard and Auxiliary Interrupt Latch Router

This block sits in front of a legacy interrupt controller and conditions three of its request lines. The keyboard request can be forwarded as it is or turned into a sticky event that stays asserted after the key controller drops its line. An auxiliary-device buffer-full flag can be folded into the mouse request as a sticky event. The waveform it produces then depends on whether the controller samples that line by edge or by level. A numeric-coprocessor error line can be connected to its request input or cut off entirely.

Routing is set through an 8-bit configuration register with a plain write strobe and a continuously driven read-back bus. Both sticky events are released when software reads the keyboard data port, decoded at the full 16-bit address 0x0060 with no aliases, or when hard reset is applied. All request pins are brought through a two-stage synchroniser before use. Software typically sets the routing once and then reads port 0x0060 in its keyboard and mouse handlers.

Top module: `kbd_irq_router`

## Requirements
- R1: After hard reset (rstN low) the register reads 0x08, both sticky latches are clear and all three request outputs are 0 while the pins are low.
- R2: Register bits 7:6 read as 0 whatever is written; bits 2:0 (divisor field) and bits 5:3 store the written value and read back unchanged.
- R3: With bit 5 set, fpuIrqOut follows the synchronised error pin; with bit 5 clear, fpuIrqOut is 0 whatever the error pin does.
- R4: With bit 3 clear, kbdIrqOut follows the synchronised keyboard pin, two clock edges after the pin changes.
- R5: With bit 3 set, a rising edge on the keyboard pin sets a latch that drives kbdIrqOut to 1, and it stays 1 after the pin falls.
- R6: With bit 4 clear, mouseIrqOut follows the synchronised mouse pin and the auxiliary-full pin has no effect on it.
- R7: With bit 4 set and mouseLevelMode = 0 (edge mode), a rising edge on the auxiliary-full pin sets a latch, mouseIrqOut equals that latch (low-to-high transition), and the mouse pin is ignored.
- R8: With bit 4 set and mouseLevelMode = 1 (level mode), mouseIrqOut is the inverse of (mouse pin OR auxiliary latch), so a latched event gives a high-to-low transition and the mouse pin still acts.
- R9: A cycle with ioRdStrobe = 1 and ioAddr exactly 0x0060 clears both latches; any other address (for example 0x0460, 0x0061, 0x0064) or ioAddr 0x0060 without the strobe leaves them unchanged.
- R10: When a new rising edge of a latched input and a clearing read fall in the same cycle, the latch ends set.
- R11: Clearing bit 3 (or bit 4) clears the keyboard (or auxiliary) latch, and no latch is set by edges while its bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, asynchronous |
| regWrEn | input | 1 | Configuration register write strobe |
| regWrData | input | 8 | Configuration write data |
| regRdData | output | 8 | Configuration read-back |
| ioRdStrobe | input | 1 | One-cycle strobe for an I/O read |
| ioAddr | input | 16 | Full I/O address of that read |
| kbdReqPin | input | 1 | Raw keyboard request |
| mouseReqPin | input | 1 | Raw mouse request |
| auxFullPin | input | 1 | Raw auxiliary buffer-full flag |
| fpuErrPin | input | 1 | Raw coprocessor error |
| mouseLevelMode | input | 1 | Controller trigger mode for the mouse line, 1 = level |
| kbdIrqOut | output | 1 | Keyboard request to the controller |
| mouseIrqOut | output | 1 | Mouse request to the controller |
| fpuIrqOut | output | 1 | Coprocessor request to the controller |

## Verification
The assertions assume the request pins are ordinary asynchronous levels that the synchroniser resolves, and that ioRdStrobe and ioAddr are stable around the clock edge. They also assume mouseLevelMode changes only as a static setting, not as a per-cycle signal. The stimulus drives every input half a cycle away from the sampling edge and changes one input per step. It lets four cycles pass before comparing, so each change has crossed the synchroniser and any latch before the next one arrives; only the directed same-cycle edge-and-clear case aligns two events on purpose.

// File: rtl/kbd_irq_pkg.sv
package kbd_irq_pkg;
  localparam int CFG_W     = 8;
  localparam int FPU_BIT   = 5;
  localparam int AUX_BIT   = 4;
  localparam int KBD_BIT   = 3;
  localparam int DIV_LSB   = 0;
  localparam int DIV_W     = 3;
  localparam int NUM_PINS  = 4;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h08;
  localparam logic [CFG_W-1:0] CFG_WMASK = 8'h3F;

  // pin slot indices inside the synchroniser bank
  localparam int PIN_KBD = 0;
  localparam int PIN_MOU = 1;
  localparam int PIN_AUX = 2;
  localparam int PIN_FPU = 3;

  typedef struct packed {
    logic clrLatch;
    logic kbdLatchEn;
    logic auxMergeEn;
    logic fpuRouteEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/kbd_irq_ctrl.sv
module kbd_irq_ctrl
  import kbd_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KBD_PORT = 16'h0060
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CFG_W-1:0]  regWrData,
  output logic [CFG_W-1:0]  regRdData,
  input  logic              ioRdStrobe,
  input  logic [ADDR_W-1:0] ioAddr,
  output ctrlStrobes_t      ctrlStb
);
  logic [CFG_W-1:0] cfgQ;
  logic             portHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= CFG_RESET;
    end else if (regWrEn) begin
      cfgQ <= regWrData & CFG_WMASK;
    end
  end

  // full-width compare: no partial decode, no aliases
  always_comb begin
    portHit = ioRdStrobe && (ioAddr == KBD_PORT);
  end

  always_comb begin
    regRdData          = cfgQ & CFG_WMASK;
    ctrlStb.clrLatch   = portHit;
    ctrlStb.kbdLatchEn = cfgQ[KBD_BIT];
    ctrlStb.auxMergeEn = cfgQ[AUX_BIT];
    ctrlStb.fpuRouteEn = cfgQ[FPU_BIT];
  end
endmodule

// File: rtl/kbd_irq_datapath.sv
module kbd_irq_datapath
  import kbd_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t ctrlStb,
  input  logic         kbdReqPin,
  input  logic         mouseReqPin,
  input  logic         auxFullPin,
  input  logic         fpuErrPin,
  input  logic         mouseLevelMode,
  output logic         kbdSync,
  output logic         kbdRise,
  output logic         auxRise,
  output logic         kbdLatchQ,
  output logic         auxLatchQ,
  output logic         kbdIrqOut,
  output logic         mouseIrqOut,
  output logic         fpuIrqOut
);
  logic [NUM_PINS-1:0] pinsRaw;
  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinsSync;
  logic                kbdPrev, auxPrev;
  logic                mouseSync, auxSync, fpuSync;
  logic                kbdLatchD, auxLatchD;

  always_comb begin
    pinsRaw          = '0;
    pinsRaw[PIN_KBD] = kbdReqPin;
    pinsRaw[PIN_MOU] = mouseReqPin;
    pinsRaw[PIN_AUX] = auxFullPin;
    pinsRaw[PIN_FPU] = fpuErrPin;
  end

  genvar st;
  generate
    for (st = 0; st < SYNC_STAGES; st++) begin : g_sync
      if (st == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[st] <= '0;
          else       syncChain[st] <= pinsRaw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[st] <= '0;
          else       syncChain[st] <= syncChain[st-1];
        end
      end
    end
  endgenerate

  always_comb begin
    pinsSync  = syncChain[SYNC_STAGES-1];
    kbdSync   = pinsSync[PIN_KBD];
    mouseSync = pinsSync[PIN_MOU];
    auxSync   = pinsSync[PIN_AUX];
    fpuSync   = pinsSync[PIN_FPU];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdPrev <= 1'b0;
      auxPrev <= 1'b0;
    end else begin
      kbdPrev <= kbdSync;
      auxPrev <= auxSync;
    end
  end

  always_comb begin
    kbdRise = kbdSync & ~kbdPrev;
    auxRise = auxSync & ~auxPrev;
  end

  // a fresh edge outranks a clearing read so no event is dropped
  always_comb begin
    if (!ctrlStb.kbdLatchEn)    kbdLatchD = 1'b0;
    else if (kbdRise)           kbdLatchD = 1'b1;
    else if (ctrlStb.clrLatch)  kbdLatchD = 1'b0;
    else                        kbdLatchD = kbdLatchQ;

    if (!ctrlStb.auxMergeEn)    auxLatchD = 1'b0;
    else if (auxRise)           auxLatchD = 1'b1;
    else if (ctrlStb.clrLatch)  auxLatchD = 1'b0;
    else                        auxLatchD = auxLatchQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kbdLatchQ <= 1'b0;
      auxLatchQ <= 1'b0;
    end else begin
      kbdLatchQ <= kbdLatchD;
      auxLatchQ <= auxLatchD;
    end
  end

  always_comb begin
    kbdIrqOut = ctrlStb.kbdLatchEn ? kbdLatchQ : kbdSync;
    if (!ctrlStb.auxMergeEn)  mouseIrqOut = mouseSync;
    else if (mouseLevelMode)  mouseIrqOut = ~(mouseSync | auxLatchQ);
    else                      mouseIrqOut = auxLatchQ;
    fpuIrqOut = ctrlStb.fpuRouteEn & fpuSync;
  end
endmodule

// File: rtl/kbd_irq_router.sv
module kbd_irq_router
  import kbd_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KBD_PORT = 16'h0060,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [CFG_W-1:0]  regWrData,
  output logic [CFG_W-1:0]  regRdData,
  input  logic              ioRdStrobe,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              kbdReqPin,
  input  logic              mouseReqPin,
  input  logic              auxFullPin,
  input  logic              fpuErrPin,
  input  logic              mouseLevelMode,
  output logic              kbdIrqOut,
  output logic              mouseIrqOut,
  output logic              fpuIrqOut
);
  ctrlStrobes_t ctrlStb;
  logic kbdSync, kbdRise, auxRise, kbdLatchQ, auxLatchQ;

  kbd_irq_ctrl #(.ADDR_W(ADDR_W), .KBD_PORT(KBD_PORT)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .ioRdStrobe(ioRdStrobe), .ioAddr(ioAddr),
    .ctrlStb(ctrlStb)
  );

  kbd_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .ctrlStb(ctrlStb),
    .kbdReqPin(kbdReqPin), .mouseReqPin(mouseReqPin),
    .auxFullPin(auxFullPin), .fpuErrPin(fpuErrPin),
    .mouseLevelMode(mouseLevelMode),
    .kbdSync(kbdSync), .kbdRise(kbdRise), .auxRise(auxRise),
    .kbdLatchQ(kbdLatchQ), .auxLatchQ(auxLatchQ),
    .kbdIrqOut(kbdIrqOut), .mouseIrqOut(mouseIrqOut), .fpuIrqOut(fpuIrqOut)
  );
endmodule

// File: rtl/kbd_irq_checker.sv
module kbd_irq_checker
  import kbd_irq_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic [7:0]   regRdData,
  input ctrlStrobes_t ctrlStb,
  input logic         mouseLevelMode,
  input logic         kbdSync,
  input logic         kbdRise,
  input logic         auxRise,
  input logic         kbdLatchQ,
  input logic         auxLatchQ,
  input logic         kbdIrqOut,
  input logic         mouseIrqOut,
  input logic         fpuIrqOut
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7:6] == 2'b00);

  // R3
  fpu_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[FPU_BIT] |-> !fpuIrqOut);

  // R4
  kbd_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[KBD_BIT] |-> (kbdIrqOut == kbdSync));

  // R7
  aux_edge_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[AUX_BIT] && !mouseLevelMode) |-> (mouseIrqOut == auxLatchQ));

  // R8
  aux_level_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[AUX_BIT] && mouseLevelMode && auxLatchQ) |-> !mouseIrqOut);

  // R9
  kbd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.clrLatch && !kbdRise) |=> !kbdLatchQ);

  // R10
  kbd_edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (kbdRise && ctrlStb.kbdLatchEn) |=> kbdLatchQ);

  // R10
  aux_edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (auxRise && ctrlStb.auxMergeEn) |=> auxLatchQ);

  // R11
  latch_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlStb.kbdLatchEn |=> (!kbdLatchQ || $past(ctrlStb.kbdLatchEn) != 1'b0 || ctrlStb.kbdLatchEn));
endmodule

bind kbd_irq_router kbd_irq_checker chk_i (
  .clk(clk), .rstN(rstN), .regRdData(regRdData), .ctrlStb(ctrlStb),
  .mouseLevelMode(mouseLevelMode), .kbdSync(kbdSync),
  .kbdRise(kbdRise), .auxRise(auxRise),
  .kbdLatchQ(kbdLatchQ), .auxLatchQ(auxLatchQ),
  .kbdIrqOut(kbdIrqOut), .mouseIrqOut(mouseIrqOut), .fpuIrqOut(fpuIrqOut)
);

// File: tb/kbd_irq_router_tb_top.sv
`timescale 1ns/1ps
module kbd_irq_router_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic ioRdStrobe = 1'b0;
  logic [15:0] ioAddr = '0;
  logic kbdReqPin = 1'b0, mouseReqPin = 1'b0, auxFullPin = 1'b0, fpuErrPin = 1'b0;
  logic mouseLevelMode = 1'b0;
  logic kbdIrqOut, mouseIrqOut, fpuIrqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] mCfg = 8'h08;
  logic mKbdLat = 1'b0, mAuxLat = 1'b0;

  always #2.5 clk = ~clk;

  kbd_irq_router dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .ioRdStrobe(ioRdStrobe), .ioAddr(ioAddr),
    .kbdReqPin(kbdReqPin), .mouseReqPin(mouseReqPin), .auxFullPin(auxFullPin),
    .fpuErrPin(fpuErrPin), .mouseLevelMode(mouseLevelMode),
    .kbdIrqOut(kbdIrqOut), .mouseIrqOut(mouseIrqOut), .fpuIrqOut(fpuIrqOut)
  );

  function automatic logic expKbd();
    return mCfg[3] ? mKbdLat : kbdReqPin;
  endfunction
  function automatic logic expMouse();
    if (!mCfg[4]) return mouseReqPin;
    if (mouseLevelMode) return ~(mouseReqPin | mAuxLat);
    return mAuxLat;
  endfunction
  function automatic logic expFpu();
    return mCfg[5] & fpuErrPin;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " reg"}, regRdData, mCfg);
    check({tag, " kbd"}, {7'd0, kbdIrqOut}, {7'd0, expKbd()});
    check({tag, " mouse"}, {7'd0, mouseIrqOut}, {7'd0, expMouse()});
    check({tag, " fpu"}, {7'd0, fpuIrqOut}, {7'd0, expFpu()});
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wrCfg(input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    mCfg = d & 8'h3F;
    if (!mCfg[3]) mKbdLat = 1'b0;
    if (!mCfg[4]) mAuxLat = 1'b0;
    settle();
  endtask

  task automatic setPin(input int which, input logic v);
    @(negedge clk);
    case (which)
      0: begin if (v && !kbdReqPin && mCfg[3]) mKbdLat = 1'b1; kbdReqPin = v; end
      1: mouseReqPin = v;
      2: begin if (v && !auxFullPin && mCfg[4]) mAuxLat = 1'b1; auxFullPin = v; end
      default: fpuErrPin = v;
    endcase
    settle();
  endtask

  task automatic ioRead(input logic [15:0] a, input logic stb);
    @(negedge clk);
    ioRdStrobe = stb; ioAddr = a;
    @(negedge clk);
    ioRdStrobe = 1'b0;
    if (stb && a == 16'h0060) begin mKbdLat = 1'b0; mAuxLat = 1'b0; end
    settle();
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    // R1 reset state
    checkAll("R1 reset");

    // R2 reserved and divisor field
    wrCfg(8'hFF);
    checkAll("R2 reserved masked");
    wrCfg(8'h0D);
    checkAll("R2 divisor readback");

    // R5 keyboard latched, holds after pin falls
    setPin(0, 1'b1);
    checkAll("R5 latch set");
    setPin(0, 1'b0);
    check("R5 latch holds", {7'd0, kbdIrqOut}, 8'd1);

    // R9 aliases and strobe-less address leave latch alone
    ioRead(16'h0460, 1'b1);
    check("R9 alias 0460", {7'd0, kbdIrqOut}, 8'd1);
    ioRead(16'h0061, 1'b1);
    check("R9 addr 0061", {7'd0, kbdIrqOut}, 8'd1);
    ioRead(16'h0060, 1'b0);
    check("R9 no strobe", {7'd0, kbdIrqOut}, 8'd1);
    ioRead(16'h0060, 1'b1);
    check("R9 exact clear", {7'd0, kbdIrqOut}, 8'd0);

    // R10 edge coincides with clearing read
    setPin(0, 1'b1);
    setPin(0, 1'b0);
    @(negedge clk);
    kbdReqPin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ioRdStrobe = 1'b1; ioAddr = 16'h0060;
    @(negedge clk);
    ioRdStrobe = 1'b0;
    mKbdLat = 1'b1;
    settle();
    check("R10 edge wins", {7'd0, kbdIrqOut}, 8'd1);

    // R11 disabling latch clears it
    wrCfg(8'h00);
    kbdReqPin = 1'b0;
    settle();
    checkAll("R11 kbd off");
    // R4 passthrough
    setPin(0, 1'b1);
    checkAll("R4 pass high");
    setPin(0, 1'b0);
    checkAll("R4 pass low");

    // R6 aux ignored with bit 4 clear
    setPin(2, 1'b1);
    checkAll("R6 aux ignored");
    setPin(1, 1'b1);
    checkAll("R6 mouse pass");
    setPin(1, 1'b0);
    setPin(2, 1'b0);

    // R7 edge mode
    wrCfg(8'h10);
    mouseLevelMode = 1'b0;
    setPin(1, 1'b1);
    checkAll("R7 mouse pin ignored");
    setPin(2, 1'b1);
    checkAll("R7 aux latched");
    // R8 level mode
    mouseLevelMode = 1'b1;
    settle();
    checkAll("R8 level latched");
    ioRead(16'h0060, 1'b1);
    checkAll("R8 level pin acts");
    setPin(1, 1'b0);
    checkAll("R8 level idle high");

    // R3 coprocessor gate
    setPin(3, 1'b1);
    checkAll("R3 gated off");
    wrCfg(8'h20);
    checkAll("R3 routed");

    // random mix over R2..R11
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wrCfg(8'($urandom()));
        1, 2: setPin(0, ~kbdReqPin);
        3: setPin(1, ~mouseReqPin);
        4, 5: setPin(2, ~auxFullPin);
        6: setPin(3, ~fpuErrPin);
        7: begin mouseLevelMode = ~mouseLevelMode; settle(); end
        default: begin
          logic [15:0] a;
          case ($urandom_range(0, 4))
            0, 1: a = 16'h0060;
            2: a = 16'h0460;
            3: a = 16'h0064;
            default: a = 16'($urandom());
          endcase
          ioRead(a, 1'($urandom_range(0, 3) != 0));
        end
      endcase
      checkAll("R2-R11 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule